// File: doc/BRIEF.md
# Per-Priority Pause Timer Bank

This block holds the pause state for each traffic priority of a link that uses priority-based flow control. An upstream parser hands it a decoded pause request. The request carries a one-cycle valid strobe, a per-priority enable vector and one 16-bit pause quanta field for each priority. For each priority the block keeps its own down-counter, measured in datapath clock cycles. It also drives a pause flag that the client's transmit scheduler uses to hold back that priority's traffic.

Requests can arrive at any time, including while the client is partway through sending a frame. Each request takes effect on the next clock edge. A priority whose enable bit is clear keeps running exactly as before. A priority whose enable bit is set is reloaded. A zero quanta value in an enabled priority releases that priority's pause at once. One quantum is 512 bit times, which is 8 cycles of a 64-bit datapath.

Top module: `pfc_pause_rx`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every remaining count is 0 and every pause flag is 0.
- R2: When `frame_valid` is high with `class_en[n]` set and quanta n greater than 0, then after that clock edge `pause_remaining` for priority n equals quanta n × 8 and `pause_active[n]` is 1.
- R3: When `frame_valid` is high with `class_en[n]` set and quanta n equal to 0, then after that clock edge priority n's count is 0 and `pause_active[n]` is 0, whatever count it held before.
- R4: When `frame_valid` is high with `class_en[n]` clear, quanta n is ignored. Priority n's count then behaves as if no request had arrived: it drops by one if it was nonzero and stays 0 if it was 0.
- R5: With no request for priority n, a nonzero count falls by exactly one per clock. `pause_active[n]` is 1 exactly while the count is nonzero, so a load of q quanta keeps the flag high for q × 8 cycles.
- R6: An enabled request replaces whatever count remains, whether the new value is longer or shorter. When requests arrive on back-to-back cycles, the later one wins.
- R7: Each priority's timer is independent. A request's effect on one priority does not alter the count of any other priority.
- R8: Bit n of `class_en` belongs to priority n. Quanta n sits at bits [16n+15:16n] of `quanta_in`. The count of priority n appears at bits [19n+18:19n] of `pause_remaining`. The largest quanta value, 0xFFFF, loads 524280 without truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | One-cycle strobe marking a decoded pause request |
| class_en | input | 8 | Per-priority enable; bit n enables priority n |
| quanta_in | input | 128 | Eight 16-bit quanta fields, priority n at [16n+15:16n] |
| pause_active | output | 8 | Pause flag per priority |
| pause_remaining | output | 152 | Eight 19-bit remaining cycle counts, priority n at [19n+18:19n] |

## Verification
On every clock, the inline assertions check the per-priority rules. These are: the load value after an enabled request, release on a zero quanta, the one-per-cycle countdown of a disabled or idle priority, and zero counts during reset. The bench scenarios are needed to show the rest. That covers the bit and field placement on the buses, the exact length of a full pause window, and reloads that are both longer and shorter. It also covers a zero quanta in a disabled priority leaving an active pause running, back-to-back requests, and the widest quanta value loading without loss.

// File: rtl/pfc_pause_rx.sv
module pfc_pause_rx #(
  parameter int NUM_PRIO       = 8,
  parameter int QUANTA_W       = 16,
  parameter int QUANTUM_CYCLES = 8,
  localparam int CNT_W         = QUANTA_W + $clog2(QUANTUM_CYCLES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_valid,
  input  logic [NUM_PRIO-1:0]        class_en,
  input  logic [NUM_PRIO*QUANTA_W-1:0] quanta_in,
  output logic [NUM_PRIO-1:0]        pause_active,
  output logic [NUM_PRIO*CNT_W-1:0]  pause_remaining
);

  for (genvar p = 0; p < NUM_PRIO; p++) begin : g_prio
    logic [CNT_W-1:0] cnt;
    logic             load;
    logic [CNT_W-1:0] reload;

    assign load   = frame_valid & class_en[p];
    assign reload = CNT_W'(quanta_in[p*QUANTA_W +: QUANTA_W]) * CNT_W'(QUANTUM_CYCLES);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= reload;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign pause_active[p]                     = (cnt != '0);
    assign pause_remaining[p*CNT_W +: CNT_W]   = cnt;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (pause_remaining[p*CNT_W +: CNT_W] == '0 && !pause_active[p]));

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && class_en[p]) |=>
        pause_remaining[p*CNT_W +: CNT_W] ==
          CNT_W'($past(quanta_in[p*QUANTA_W +: QUANTA_W])) * CNT_W'(QUANTUM_CYCLES));

    // R3
    zero_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && class_en[p] && quanta_in[p*QUANTA_W +: QUANTA_W] == '0) |=>
        !pause_active[p]);

    // R4
    ignore_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(frame_valid && class_en[p]) && pause_active[p]) |=>
        pause_remaining[p*CNT_W +: CNT_W] == $past(pause_remaining[p*CNT_W +: CNT_W]) - 1'b1);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(frame_valid && class_en[p]) && !pause_active[p]) |=> !pause_active[p]);

    // R5
    flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pause_active[p] == (pause_remaining[p*CNT_W +: CNT_W] != '0));
  end

endmodule

// File: tb/pfc_pause_rx_tb.sv
`timescale 1ns/1ps
module pfc_pause_rx_tb_top;
  localparam int NP = 8;
  localparam int QW = 16;
  localparam int CW = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic frame_valid = 1'b0;
  logic [NP-1:0] class_en = '0;
  logic [NP*QW-1:0] quanta_in = '0;
  logic [NP-1:0] pause_active;
  logic [NP*CW-1:0] pause_remaining;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int    q_cyc[$];
  int    q_lane[$];
  int    q_rem[$];
  string q_tag[$];

  pfc_pause_rx dut_i (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .class_en(class_en),
    .quanta_in(quanta_in), .pause_active(pause_active), .pause_remaining(pause_remaining)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int dc, input int lane, input int rem, input string tag);
    q_cyc.push_back(cyc + dc);
    q_lane.push_back(lane);
    q_rem.push_back(rem);
    q_tag.push_back(tag);
  endtask

  task automatic send(input logic [NP-1:0] en);
    class_en    = en;
    frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  task automatic setq(input int lane, input int v);
    quanta_in[lane*QW +: QW] = QW'(v);
  endtask

  always @(negedge clk) begin
    for (int k = q_cyc.size() - 1; k >= 0; k--) begin
      if (q_cyc[k] <= cyc) begin
        int rem_act;
        bit act_act;
        rem_act = int'(pause_remaining[q_lane[k]*CW +: CW]);
        act_act = pause_active[q_lane[k]];
        total++;
        if (q_cyc[k] < cyc) begin
          bad++;
          $display("FAIL %s lane %0d: check missed (cycle %0d, now %0d)", q_tag[k], q_lane[k], q_cyc[k], cyc);
        end else if (rem_act != q_rem[k] || act_act != (q_rem[k] != 0)) begin
          bad++;
          $display("FAIL %s lane %0d cyc %0d: remaining=%0d active=%0b expected remaining=%0d active=%0b",
                   q_tag[k], q_lane[k], cyc, rem_act, act_act, q_rem[k], q_rem[k] != 0);
        end
        q_cyc.delete(k); q_lane.delete(k); q_rem.delete(k); q_tag.delete(k);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: cleared state right after reset
    for (int n = 0; n < NP; n++) expect_at(1, n, 0, "R1");
    repeat (3) @(negedge clk);

    // R2 / R4 / R7 / R8: two lanes enabled, others carry ignored quanta
    for (int n = 0; n < NP; n++) setq(n, 7);
    setq(0, 3); setq(2, 1);
    expect_at(1, 0, 24, "R2");
    expect_at(1, 2, 8, "R8");
    expect_at(1, 1, 0, "R4");
    expect_at(1, 7, 0, "R4");
    expect_at(8, 2, 1, "R5");
    expect_at(9, 2, 0, "R5");
    expect_at(9, 0, 16, "R7");
    expect_at(24, 0, 1, "R5");
    expect_at(25, 0, 0, "R5");
    send(8'b0000_0101);
    repeat (30) @(negedge clk);

    // R6: reload longer then shorter then longer
    quanta_in = '0;
    setq(0, 10);
    expect_at(1, 0, 80, "R6");
    send(8'h01);
    repeat (4) @(negedge clk);
    expect_at(0 + 1, 0, 16, "R6");
    setq(0, 2);
    send(8'h01);
    repeat (3) @(negedge clk);
    expect_at(1, 0, 800, "R6");
    setq(0, 100);
    send(8'h01);
    repeat (10) @(negedge clk);

    // R3: zero quanta releases lane 0; lane 3 loads in the same request (R7)
    setq(0, 0); setq(3, 5);
    expect_at(1, 0, 0, "R3");
    expect_at(1, 3, 40, "R7");
    send(8'h09);
    @(negedge clk);
    // R4: disabled lane 3 ignores a new quanta and keeps counting
    setq(3, 9);
    expect_at(1, 3, 38, "R4");
    expect_at(1, 0, 0, "R4");
    send(8'h00);
    // R4: zero quanta on a disabled lane does not release it
    quanta_in = '0;
    expect_at(1, 3, 37, "R4");
    send(8'hF7);
    repeat (50) @(negedge clk);

    // R8: widest quanta on every lane
    for (int n = 0; n < NP; n++) setq(n, 16'hFFFF);
    for (int n = 0; n < NP; n++) expect_at(1, n, 524280, "R8");
    send(8'hFF);
    for (int n = 0; n < NP; n++) expect_at(2, n, 524278, "R5");
    repeat (3) @(negedge clk);
    quanta_in = '0;
    for (int n = 0; n < NP; n++) expect_at(1, n, 0, "R3");
    send(8'hFF);
    repeat (2) @(negedge clk);

    // R6: back-to-back requests, later one wins
    setq(1, 4);
    class_en = 8'h02;
    frame_valid = 1'b1;
    expect_at(2, 1, 16, "R6");
    expect_at(2, 5, 0, "R7");
    @(negedge clk);
    setq(1, 2);
    @(negedge clk);
    frame_valid = 1'b0;
    repeat (3) @(negedge clk);

    if (q_cyc.size() != 0) begin
      total++; bad++;
      $display("FAIL R5: %0d expectations left unchecked, expected 0", q_cyc.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule